// File: doc/BRIEF.md
# Pipelined 40-bit SPI Register Slave

This block lets an SPI host reach a bank of 32-bit registers. Each transfer is a 40-bit frame sent most significant bit first. The top bit of the frame selects write (1) or read (0). The next 7 bits carry the register address, and the low 32 bits carry right-aligned data. The SPI pins are brought into a faster system clock through plain synchronisers. All serial activity runs from edges detected in that domain, so SCK may run at no more than half the system clock rate. The command takes effect when chip select returns high.

Replies lag one frame behind. While a frame is being clocked in, the block shifts out a reply built at the end of the previous complete frame. That reply has two parts:
- An 8-bit status byte, which takes the place of the address field. It holds three external status inputs in its top bits, with zeros below them.
- The data of the previous frame: the register contents for a read, or the echoed data for a write.

Extra clocks beyond 40 push the incoming bits out of SDO 40 clocks later, which lets several slaves be chained. The register bank itself sits outside the block, behind a one-cycle-latency port of the kind a block RAM provides.

Top module: `spi40_slave`

## Requirements
- R1: A complete 40-bit frame with bit 39 = 1 gives exactly one `reg_wr_en` pulse after CSN rises. It presents `reg_addr` = bits 38..32 and `reg_wdata` = bits 31..0, with the first bit received taken as bit 39.
- R2: A complete frame with bit 39 = 0 gives exactly one `reg_rd_en` pulse at `reg_addr` = bits 38..32. The register value returned one cycle later appears in bits 31..0 of the next frame's reply.
- R3: After a complete write frame, bits 31..0 of the next frame's reply equal the written data.
- R4: Reply bits 39..32 equal {status_in[2], status_in[1], status_in[0], 5'b00000}, as sampled when the previous complete frame ended.
- R5: SPI mode 3 is used. SDI is sampled on rising SCK. Reply bit 39 is on SDO before the first rising SCK, and each later bit is driven after a falling SCK edge.
- R6: `spi_sdo_oe` is low whenever CSN is high and high during a frame.
- R7: If more than 40 bits are clocked, each bit received comes out on SDO 40 clocks later. Only the last 40 bits received form the command.
- R8: A frame of fewer than 40 bits issues no register access. It leaves the next reply (status and data) as it was.
- R9: `reg_wr_en` and `reg_rd_en` are never high together, and each is high for one cycle only.
- R10: The read value is captured once, right after the read frame. Later changes to the register do not alter the reply shifted out in the next frame.
- R11: After reset, SDO, `spi_sdo_oe`, `reg_wr_en` and `reg_rd_en` are low, and the first reply is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock, idles high |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_oe | output | 1 | Output enable for SDO pad driver |
| status_in | input | 3 | Status bits shown in the reply's top byte |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_addr | output | 7 | Register address |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, valid one cycle after `reg_rd_en` |

## Verification
The bench builds the block with its defaults: 7 address bits, 32 data bits, three status inputs and two synchroniser stages. These are the widths at which the 40-bit frame, the status byte layout and the full 128-entry address space exist. SCK runs at one twelfth of the system clock, which leaves room for the synchroniser delay between a falling SCK edge and the next sample. The 50-bit and 20-bit frames check that the bit counter saturates and that a short frame leaves the reply unchanged. A read followed by a register change checks that the captured reply does not move while it is shifted out.

// File: rtl/spi40_pkg.sv
package spi40_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } spi40_op_e;
endpackage

// File: rtl/spi40_sync.sv
module spi40_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi40_shift.sv
module spi40_shift #(
  parameter int FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic               bit_in_stb,
  input  logic               bit_out_stb,
  input  logic               sdi,
  input  logic [FRAME_W-1:0] load_val,
  output logic [FRAME_W-1:0] frame_q,
  output logic               frame_full,
  output logic               sdo
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      bit_cnt <= '0;
    end else if (frame_start) begin
      frame_q <= load_val;
      bit_cnt <= '0;
    end else if (bit_in_stb) begin
      frame_q <= {frame_q[FRAME_W-2:0], sdi};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              sdo <= 1'b0;
    else if (frame_start) sdo <= load_val[FRAME_W-1];
    else if (bit_out_stb) sdo <= frame_q[FRAME_W-1];
  end

  assign frame_full = (bit_cnt == CNT_MAX);
endmodule

// File: rtl/spi40_exec.sv
module spi40_exec
  import spi40_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int NSTAT  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     exec,
  input  logic [ADDR_W+DATA_W:0]   frame,
  input  logic [NSTAT-1:0]         status_in,
  input  logic [DATA_W-1:0]        reg_rdata,
  output logic                     reg_wr_en,
  output logic                     reg_rd_en,
  output logic [ADDR_W-1:0]        reg_addr,
  output logic [DATA_W-1:0]        reg_wdata,
  output logic [ADDR_W:0]          reply_status,
  output logic [DATA_W-1:0]        reply_data
);
  localparam int STAT_W = ADDR_W + 1;
  localparam int PAD_W  = STAT_W - NSTAT;
  localparam int TOP    = ADDR_W + DATA_W;

  spi40_op_e op;
  logic      rd_pend;

  always_comb begin
    if (!exec)          op = OP_IDLE;
    else if (frame[TOP]) op = OP_WRITE;
    else                op = OP_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      rd_pend   <= 1'b0;
    end else begin
      reg_wr_en <= (op == OP_WRITE);
      reg_rd_en <= (op == OP_READ);
      rd_pend   <= reg_rd_en;
      if (op != OP_IDLE) begin
        reg_addr  <= frame[TOP-1:DATA_W];
        reg_wdata <= frame[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reply_status <= '0;
      reply_data   <= '0;
    end else begin
      if (op != OP_IDLE) reply_status <= {status_in, {PAD_W{1'b0}}};
      if (op == OP_WRITE) reply_data <= frame[DATA_W-1:0];
      else if (rd_pend)   reply_data <= reg_rdata;
    end
  end
endmodule

// File: rtl/spi40_slave.sv
module spi40_slave #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int NSTAT  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  input  logic [NSTAT-1:0]  status_in,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;

  logic sck_s, csn_s, sdi_s;
  logic sck_d, csn_d;
  logic sck_rise, sck_fall, csn_fall, csn_rise;
  logic frame_full;
  logic [FRAME_W-1:0] frame_q;
  logic [ADDR_W:0]    reply_status;
  logic [DATA_W-1:0]  reply_data;

  spi40_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({csn_in_w, spi_sck, spi_sdi}),
    .q   ({csn_s, sck_s, sdi_s})
  );

  logic csn_in_w;
  assign csn_in_w = spi_csn;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d      <= 1'b1;
      csn_d      <= 1'b1;
      spi_sdo_oe <= 1'b0;
    end else begin
      sck_d      <= sck_s;
      csn_d      <= csn_s;
      spi_sdo_oe <= ~csn_s;
    end
  end

  assign sck_rise = ~csn_s & sck_s & ~sck_d;
  assign sck_fall = ~csn_s & ~sck_s & sck_d;
  assign csn_fall = ~csn_s & csn_d;
  assign csn_rise = csn_s & ~csn_d;

  spi40_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .frame_start (csn_fall),
    .bit_in_stb  (sck_rise),
    .bit_out_stb (sck_fall),
    .sdi         (sdi_s),
    .load_val    ({reply_status, reply_data}),
    .frame_q     (frame_q),
    .frame_full  (frame_full),
    .sdo         (spi_sdo)
  );

  spi40_exec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSTAT(NSTAT)) u_exec (
    .clk          (clk),
    .rst          (rst),
    .exec         (csn_rise & frame_full),
    .frame        (frame_q),
    .status_in    (status_in),
    .reg_rdata    (reg_rdata),
    .reg_wr_en    (reg_wr_en),
    .reg_rd_en    (reg_rd_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reply_status (reply_status),
    .reply_data   (reply_data)
  );
endmodule

// File: rtl/spi40_slave_chk.sv
module spi40_slave_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              csn_s,
  input logic              sck_fall,
  input logic              spi_sdo,
  input logic              spi_sdo_oe,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] reply_data
);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_wr_en, reg_rd_en}));

  assert_wr_single_R9: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);

  assert_rd_single_R9: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> !reg_rd_en);

  assert_rd_capture_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> ##1 (reply_data == $past(reg_rdata)));

  assert_oe_idle_R6: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !spi_sdo_oe);

  assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (spi_sdo_oe && $past(spi_sdo_oe) && !$past(sck_fall)) |-> $stable(spi_sdo));
endmodule

bind spi40_slave spi40_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .csn_s      (csn_s),
  .sck_fall   (sck_fall),
  .spi_sdo    (spi_sdo),
  .spi_sdo_oe (spi_sdo_oe),
  .reg_wr_en  (reg_wr_en),
  .reg_rd_en  (reg_rd_en),
  .reg_rdata  (reg_rdata),
  .reply_data (reply_data)
);

// File: tb/spi40_slave_tb.sv
`timescale 1ns/1ps
module spi40_slave_tb;
  localparam int HP  = 6;
  localparam int GAP = 14;
  localparam int NV  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b1, spi_csn = 1'b1, spi_sdi = 1'b0;
  logic spi_sdo, spi_sdo_oe;
  logic [2:0] status_in = 3'b000;
  logic reg_wr_en, reg_rd_en;
  logic [6:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #5 clk = ~clk;

  spi40_slave u_dut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_sdi(spi_sdi),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe), .status_in(status_in),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // register bank model with one-cycle read latency
  logic [31:0] mem [128];
  logic        poke_en = 1'b0;
  logic [6:0]  poke_addr = '0;
  logic [31:0] poke_data = '0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [6:0]  last_addr;
  logic [31:0] last_wdata;

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'hA5000000 ^ (i * 32'h00010203);
  end

  always @(posedge clk) begin
    reg_rdata <= mem[reg_addr];
    if (reg_wr_en) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
      last_wdata <= reg_wdata;
    end else if (poke_en) begin
      mem[poke_addr] <= poke_data;
    end
    if (reg_rd_en) rd_cnt <= rd_cnt + 1;
    if (reg_wr_en || reg_rd_en) last_addr <= reg_addr;
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [79:0] tx, output logic [79:0] rx, output bit oe_ok);
    rx = '0;
    oe_ok = 1;
    spi_csn = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      spi_sck = 1'b0;
      spi_sdi = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = spi_sdo;
      if (spi_sdo_oe !== 1'b1) oe_ok = 0;
      spi_sck = 1'b1;
      repeat (HP) @(negedge clk);
    end
    spi_csn = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  // shadow model of the pipelined reply
  logic [31:0] shadow [128];
  logic [7:0]  exp_stat = 8'h00;
  logic [31:0] exp_data = 32'h0;

  task automatic full_frame(input string req, input logic [2:0] st, input logic [39:0] cmd);
    logic [79:0] rx;
    bit oe_ok;
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    status_in = st;
    xfer(40, {40'h0, cmd}, rx, oe_ok);
    check({req, " reply"}, {40'h0, rx[39:0]}, {40'h0, exp_stat, exp_data});
    check("R6 oe during frame", {79'h0, oe_ok}, 80'h1);
    check({req, " wr count"}, 80'(wr_cnt - w0), 80'(cmd[39] ? 1 : 0));
    check({req, " rd count"}, 80'(rd_cnt - r0), 80'(cmd[39] ? 0 : 1));
    check("R1 R2 addr", {73'h0, last_addr}, {73'h0, cmd[38:32]});
    if (cmd[39]) begin
      check("R1 wdata", {48'h0, last_wdata}, {48'h0, cmd[31:0]});
      shadow[cmd[38:32]] = cmd[31:0];
      exp_data = cmd[31:0];
    end else begin
      exp_data = shadow[cmd[38:32]];
    end
    exp_stat = {st, 5'b0};
  endtask

  // status(3) & frame(40)
  localparam logic [42:0] VEC [NV] = '{
    {3'b000, 1'b1, 7'h05, 32'hDEADBEEF},
    {3'b001, 1'b0, 7'h05, 32'h00000000},
    {3'b010, 1'b0, 7'h7F, 32'hFFFFFFFF},
    {3'b100, 1'b1, 7'h00, 32'h00000001},
    {3'b111, 1'b1, 7'h7F, 32'h80000000},
    {3'b011, 1'b0, 7'h00, 32'h12345678},
    {3'b101, 1'b0, 7'h7F, 32'h0},
    {3'b110, 1'b0, 7'h22, 32'h0}
  };

  initial begin
    logic [79:0] rx;
    logic [79:0] tx;
    bit oe_ok;
    int w0, r0;
    for (int i = 0; i < 128; i++) shadow[i] = 32'hA5000000 ^ (i * 32'h00010203);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 sdo_oe", {79'h0, spi_sdo_oe}, 80'h0);
    check("R11 sdo", {79'h0, spi_sdo}, 80'h0);
    check("R11 strobes", {78'h0, reg_wr_en, reg_rd_en}, 80'h0);
    check("R11 counts", 80'(wr_cnt + rd_cnt), 80'h0);

    // R1 R2 R3 R4 R5: table of frames
    for (int v = 0; v < NV; v++)
      full_frame("R1 R2 R3 R4 R5 R11", VEC[v][42:40], VEC[v][39:0]);
    check("R6 oe after frame", {79'h0, spi_sdo_oe}, 80'h0);

    // R10: read, then change the register before the reply shifts out
    full_frame("R2", 3'b001, {1'b0, 7'h33, 32'h0});
    poke_addr = 7'h33; poke_data = 32'h0BADF00D; poke_en = 1'b1;
    @(negedge clk); poke_en = 1'b0;
    shadow[7'h33] = 32'h0BADF00D;
    full_frame("R10", 3'b001, {1'b0, 7'h33, 32'h0});
    full_frame("R10 new value", 3'b000, {1'b1, 7'h10, 32'hCAFE0001});

    // R7: 50-bit frame, first 10 bits pass through, last 40 bits are the command
    tx = {30'h0, 10'h2B5, 1'b1, 7'h44, 32'h13579BDF};
    w0 = wr_cnt;
    status_in = 3'b010;
    xfer(50, tx, rx, oe_ok);
    check("R7 passthrough", {70'h0, rx[9:0]}, {70'h0, tx[49:40]});
    check("R7 reply", {40'h0, rx[49:10]}, {40'h0, exp_stat, exp_data});
    check("R7 wr count", 80'(wr_cnt - w0), 80'h1);
    check("R7 addr", {73'h0, last_addr}, 80'h44);
    check("R7 data", {48'h0, last_wdata}, 80'h13579BDF);
    shadow[7'h44] = 32'h13579BDF;
    exp_data = 32'h13579BDF;
    exp_stat = 8'h40;

    // R8: 20-bit frame is ignored; status change is not captured
    w0 = wr_cnt; r0 = rd_cnt;
    status_in = 3'b111;
    xfer(20, {60'h0, 1'b1, 7'h01, 12'hFFF}, rx, oe_ok);
    check("R8 no access", 80'((wr_cnt - w0) + (rd_cnt - r0)), 80'h0);
    check("R8 partial reply", {60'h0, rx[19:0]}, {60'h0, exp_stat, exp_data[31:20]});
    full_frame("R8", 3'b000, {1'b0, 7'h01, 32'h0});
    full_frame("R3", 3'b000, {1'b0, 7'h44, 32'h0});
    full_frame("R2", 3'b000, {1'b0, 7'h00, 32'h0});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule